// File: doc/BRIEF.md
# IDE Window Configuration and Access Trap Controller

This block watches the eight-byte primary IDE register window of a local-bus disk interface. In normal mode each access is meant for the drive. The block enables the channel towards the drive and reports every read as all ones. The drive's own data is merged outside the block. When trapping is enabled, each access in the window also raises a one-cycle SMI request. The block then records which part of the window was touched and how wide the access was, so that a power-management handler can replay or emulate it.

The same window also hides a small configuration register file. A fixed read sequence at offset 1 swaps the window into configuration mode. Reads and writes then reach the internal registers instead of the drive. A control write at offset 2 returns the window to normal mode, and it can lock configuration mode out until the next reset. Two offsets are banked through a select register. Two other registers apply fixed write masks.

Each access is offered for one cycle on the access port. It is acted on at that clock edge. Read data, the SMI pulse and the capture registers change at that same edge, so they are visible in the following cycle.

Top module: `ide_window_ctl`

## Requirements
- R1: In normal mode, every second 16-bit read (size code 1) at window offset 1 switches the window into configuration mode, unless the lock is set. The count lives in a 1-bit toggle that starts at zero on reset. Byte reads, 32-bit reads and writes at offset 1 leave the toggle unchanged. Accesses in configuration mode also leave it unchanged.
- R2: In configuration mode, a write at offset 2 whose data has bit 7 or bit 6 set returns the window to normal mode in the next cycle. A write at offset 2 with both bits clear keeps configuration mode.
- R3: A configuration write at offset 2 with data bit 6 set sets a lock. While the lock is set, no read sequence re-enters configuration mode. Only reset clears the lock.
- R4: When control register (offset 3) bit 1 is set, every normal-mode access produces `smi_pulse` high for exactly the next cycle. The pulse does not occur when that bit is clear. It never occurs for accesses made in configuration mode.
- R5: A trapped access loads the trap code register. Bit 5 of that register holds address bit 9 (`acc_upper`), bit 4 holds offset bit 2, and bits 1:0 hold the lane code; all other bits are zero. The lane code is offset bits 1:0 for a byte access (size 0). It is {offset bit 1, 1} for a 16-bit access (size 1), and 3 for a 32-bit access (size 2 or 3).
- R6: A trapped byte write loads its data byte into the trap data register. Every other trapped access clears that register.
- R7: Every read returns `rd_valid` high in the next cycle. In normal mode `rd_data` is all ones.
- R8: Configuration offsets 0 and 1 are banked. Bit 0 of the select register (offset 6) picks the bank, and each bank holds its own two bytes.
- R9: A write to offset 3 stores the data with bit 5 forced to zero. A write to offset 5 replaces bits 7 and 2:0 and keeps bits 6:3.
- R10: A configuration read at offset 2 returns the `smm_active` level in bit 7. Bits 6:0 show the trap code while `smm_active` is high and read zero otherwise. Offset 4 reads the trap data register. Offsets 3, 5 and 6 read back their registers. Configuration reads place the byte in `rd_data[7:0]`, with all higher bits one.
- R11: After reset the window is in normal mode, control (offset 3) reads 01h, offset 5 reads 20h, and all other registers read zero.
- R12: `drv_enable` is high exactly when the window is in normal mode and control bit 0 is set.
- R13: In configuration mode, offset 7 reads FFh. Writes to offsets 4 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One access offered this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 16-bit, 2 or 3 32-bit |
| acc_off | input | 3 | Offset within the window (address bits 2:0) |
| acc_upper | input | 1 | Address bit 9 (control-block alias of the window) |
| acc_wdata | input | 8 | Write data byte |
| smm_active | input | 1 | System management mode is active |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | DATA_W | Read response data |
| smi_pulse | output | 1 | One-cycle SMI request per trapped access |
| cfg_mode | output | 1 | Window is in configuration mode |
| drv_enable | output | 1 | Accesses are passed to the drive channel |
| trap_code | output | 8 | Captured trap code |
| trap_data | output | 8 | Captured trap data byte |

## Verification
The assertions assume that at most one access is presented per cycle. They also assume that `acc_valid` stays low while reset is asserted, so no `$past` sample reaches back across reset. The size code is taken as always meaningful, with code 3 treated as 32-bit. The bench drives every access for exactly one cycle, between two falling edges, and holds `acc_valid` low during reset. The exhaustive trap sweep leaves out 16-bit reads at offset 1. This keeps the entry toggle from advancing between the captures it checks.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_WIDE  = 2'd3
    } acc_size_e;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_CONFIG = 1'b1
    } win_mode_e;

    localparam logic [2:0] OFF_BANK_LO = 3'd0;
    localparam logic [2:0] OFF_BANK_HI = 3'd1;
    localparam logic [2:0] OFF_CTL     = 3'd2;
    localparam logic [2:0] OFF_CTRL    = 3'd3;
    localparam logic [2:0] OFF_TDATA   = 3'd4;
    localparam logic [2:0] OFF_AUX     = 3'd5;
    localparam logic [2:0] OFF_BSEL    = 3'd6;

    localparam logic [7:0] CTRL_RST     = 8'h01;
    localparam logic [7:0] AUX_RST      = 8'h20;
    localparam logic [7:0] CTRL_WMASK   = 8'hDF;
    localparam logic [7:0] AUX_KEEP     = 8'h78;
    localparam logic [7:0] AUX_REPLACE  = 8'h87;

    localparam int CTRL_PASS_BIT = 0;
    localparam int CTRL_TRAP_BIT = 1;
    localparam int CTL_EXIT_BIT  = 7;
    localparam int CTL_LOCK_BIT  = 6;

endpackage

// File: rtl/ide_trap_enc.sv
module ide_trap_enc
    import ide_win_pkg::*;
(
    input  logic [1:0] size,
    input  logic [2:0] off,
    input  logic       upper,
    input  logic       write,
    input  logic [7:0] wbyte,
    output logic [7:0] code,
    output logic [7:0] data
);
    logic [1:0] lanes;

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: lanes = off[1:0];
            SZ_WORD: lanes = {off[1], 1'b1};
            default: lanes = 2'b11;
        endcase
        code = {2'b00, upper, off[2], 2'b00, lanes};
        data = (write && (acc_size_e'(size) == SZ_BYTE)) ? wbyte : 8'h00;
    end
endmodule

// File: rtl/ide_mode_seq.sv
module ide_mode_seq
    import ide_win_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic entry_tick,
    input  logic exit_tick,
    input  logic lock_tick,
    output logic in_cfg
);
    typedef struct packed {
        win_mode_e mode;
        logic      toggle;
        logic      locked;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (entry_tick) begin
            s_d.toggle = ~s_q.toggle;
            if (s_q.toggle && !s_q.locked)
                s_d.mode = MODE_CONFIG;
        end
        if (exit_tick)
            s_d.mode = MODE_NORMAL;
        if (lock_tick)
            s_d.locked = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '{mode: MODE_NORMAL, toggle: 1'b0, locked: 1'b0};
        else
            s_q <= s_d;
    end

    assign in_cfg = (s_q.mode == MODE_CONFIG);
endmodule

// File: rtl/ide_cfg_file.sv
module ide_cfg_file
    import ide_win_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [2:0] off,
    input  logic [7:0] wbyte,
    input  logic       smm_active,
    input  logic       trap_fire,
    input  logic [7:0] code_in,
    input  logic [7:0] data_in,
    output logic [7:0] rd_byte,
    output logic [7:0] ctrl,
    output logic [7:0] trap_code,
    output logic [7:0] trap_data
);
    localparam int BSEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    typedef struct packed {
        logic [NUM_BANKS-1:0][1:0][7:0] bank;
        logic [7:0] tcode;
        logic [7:0] ctrl;
        logic [7:0] tdata;
        logic [7:0] aux;
        logic [7:0] bsel;
    } regs_t;

    regs_t r_d, r_q;
    logic [BSEL_W-1:0] bidx;

    assign bidx = r_q.bsel[BSEL_W-1:0];

    always_comb begin
        r_d = r_q;
        if (trap_fire) begin
            r_d.tcode = code_in;
            r_d.tdata = data_in;
        end
        if (cfg_wr) begin
            unique case (off)
                OFF_BANK_LO, OFF_BANK_HI: r_d.bank[bidx][off[0]] = wbyte;
                OFF_CTRL: r_d.ctrl = wbyte & CTRL_WMASK;
                OFF_AUX:  r_d.aux  = (r_q.aux & AUX_KEEP) | (wbyte & AUX_REPLACE);
                OFF_BSEL: r_d.bsel = wbyte;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (off)
            OFF_BANK_LO, OFF_BANK_HI: rd_byte = r_q.bank[bidx][off[0]];
            OFF_CTL:   rd_byte = {smm_active, smm_active ? r_q.tcode[6:0] : 7'h00};
            OFF_CTRL:  rd_byte = r_q.ctrl;
            OFF_TDATA: rd_byte = r_q.tdata;
            OFF_AUX:   rd_byte = r_q.aux;
            OFF_BSEL:  rd_byte = r_q.bsel;
            default:   rd_byte = 8'hFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.ctrl <= CTRL_RST;
            r_q.aux  <= AUX_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl      = r_q.ctrl;
    assign trap_code = r_q.tcode;
    assign trap_data = r_q.tdata;
endmodule

// File: rtl/ide_window_ctl.sv
module ide_window_ctl
    import ide_win_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_size,
    input  logic [2:0]        acc_off,
    input  logic              acc_upper,
    input  logic [7:0]        acc_wdata,
    input  logic              smm_active,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              smi_pulse,
    output logic              cfg_mode,
    output logic              drv_enable,
    output logic [7:0]        trap_code,
    output logic [7:0]        trap_data
);
    localparam int PAD_W = DATA_W - 8;

    typedef struct packed {
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic              smi;
    } out_t;

    out_t o_d, o_q;

    logic       in_cfg;
    logic       entry_tick, exit_tick, lock_tick;
    logic       trap_fire, cfg_wr;
    logic [7:0] ctrl, rd_byte, enc_code, enc_data;

    assign entry_tick = acc_valid && !acc_write && !in_cfg &&
                        (acc_size_e'(acc_size) == SZ_WORD) && (acc_off == OFF_BANK_HI);
    assign cfg_wr     = acc_valid && acc_write && in_cfg;
    assign exit_tick  = cfg_wr && (acc_off == OFF_CTL) &&
                        (acc_wdata[CTL_EXIT_BIT] || acc_wdata[CTL_LOCK_BIT]);
    assign lock_tick  = cfg_wr && (acc_off == OFF_CTL) && acc_wdata[CTL_LOCK_BIT];
    assign trap_fire  = acc_valid && !in_cfg && ctrl[CTRL_TRAP_BIT];

    ide_mode_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .entry_tick (entry_tick),
        .exit_tick  (exit_tick),
        .lock_tick  (lock_tick),
        .in_cfg     (in_cfg)
    );

    ide_trap_enc u_enc (
        .size  (acc_size),
        .off   (acc_off),
        .upper (acc_upper),
        .write (acc_write),
        .wbyte (acc_wdata),
        .code  (enc_code),
        .data  (enc_data)
    );

    ide_cfg_file #(.NUM_BANKS(NUM_BANKS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .off        (acc_off),
        .wbyte      (acc_wdata),
        .smm_active (smm_active),
        .trap_fire  (trap_fire),
        .code_in    (enc_code),
        .data_in    (enc_data),
        .rd_byte    (rd_byte),
        .ctrl       (ctrl),
        .trap_code  (trap_code),
        .trap_data  (trap_data)
    );

    always_comb begin
        o_d        = o_q;
        o_d.smi    = trap_fire;
        o_d.rvalid = acc_valid && !acc_write;
        if (acc_valid && !acc_write)
            o_d.rdata = in_cfg ? {{PAD_W{1'b1}}, rd_byte} : {DATA_W{1'b1}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            o_q <= '{rvalid: 1'b0, rdata: {DATA_W{1'b1}}, smi: 1'b0};
        else
            o_q <= o_d;
    end

    assign rd_valid   = o_q.rvalid;
    assign rd_data    = o_q.rdata;
    assign smi_pulse  = o_q.smi;
    assign cfg_mode   = in_cfg;
    assign drv_enable = !in_cfg && ctrl[CTRL_PASS_BIT];
endmodule

// File: rtl/ide_window_ctl_chk.sv
module ide_window_ctl_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [1:0]        acc_size,
    input logic [2:0]        acc_off,
    input logic [7:6]        wtop,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              smi_pulse,
    input logic              cfg_mode,
    input logic              drv_enable,
    input logic [1:0]        lane_code,
    input logic [7:0]        trap_data
);
    logic locked_seen;

    always_ff @(posedge clk) begin
        if (!rst_n)
            locked_seen <= 1'b0;
        else if (acc_valid && acc_write && cfg_mode && acc_off == 3'd2 && wtop[6])
            locked_seen <= 1'b1;
    end

    // R1
    enter_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_mode) |-> $past(acc_valid && !acc_write && acc_size == 2'd1 && acc_off == 3'd1));

    // R2
    exit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_mode) |-> $past(acc_valid && acc_write && acc_off == 3'd2 && (wtop != 2'b00)));

    // R3
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_seen |-> !cfg_mode);

    // R4
    smi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse |-> $past(acc_valid) && !$past(cfg_mode));

    // R5
    lane_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse |-> lane_code == (($past(acc_size) == 2'd0) ? $past(acc_off[1:0]) :
                                    ($past(acc_size) == 2'd1) ? {$past(acc_off[1]), 1'b1} : 2'b11));

    // R6
    data_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_pulse && !($past(acc_write) && $past(acc_size) == 2'd0)) |-> trap_data == 8'h00);

    // R7
    normal_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !$past(cfg_mode)) |-> rd_data == {DATA_W{1'b1}});

    // R12
    drv_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_enable |-> !cfg_mode);
endmodule

bind ide_window_ctl ide_window_ctl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_size   (acc_size),
    .acc_off    (acc_off),
    .wtop       (acc_wdata[7:6]),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .smi_pulse  (smi_pulse),
    .cfg_mode   (cfg_mode),
    .drv_enable (drv_enable),
    .lane_code  (trap_code[1:0]),
    .trap_data  (trap_data)
);

// File: tb/ide_window_ctl_tb.sv
module ide_window_ctl_tb;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0, acc_write = 1'b0, acc_upper = 1'b0, smm_active = 1'b0;
    logic [1:0]    acc_size = 2'd0;
    logic [2:0]    acc_off = 3'd0;
    logic [7:0]    acc_wdata = 8'h00;
    logic          rd_valid, smi_pulse, cfg_mode, drv_enable;
    logic [DW-1:0] rd_data;
    logic [7:0]    trap_code, trap_data;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    ide_window_ctl #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_size(acc_size), .acc_off(acc_off), .acc_upper(acc_upper),
        .acc_wdata(acc_wdata), .smm_active(smm_active), .rd_valid(rd_valid),
        .rd_data(rd_data), .smi_pulse(smi_pulse), .cfg_mode(cfg_mode),
        .drv_enable(drv_enable), .trap_code(trap_code), .trap_data(trap_data)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one access for one cycle; returns at the falling edge after it was taken
    task automatic acc(input logic w, input logic [1:0] sz, input logic [2:0] off,
                       input logic up, input logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_size = sz; acc_off = off;
        acc_upper = up; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic cfg_rd(input logic [2:0] off, input logic [7:0] exp, input string req);
        acc(1'b0, 2'd0, off, 1'b0, 8'h00);
        check(req, rd_data, {24'hFFFFFF, exp});
    endtask

    task automatic cfg_wr(input logic [2:0] off, input logic [7:0] d);
        acc(1'b1, 2'd0, off, 1'b0, d);
    endtask

    task automatic word_rd1();
        acc(1'b0, 2'd1, 3'd1, 1'b0, 8'h00);
    endtask

    function automatic logic [7:0] exp_code(input logic up, input logic [2:0] off, input logic [1:0] sz);
        logic [1:0] be;
        be = (sz == 2'd0) ? off[1:0] : (sz == 2'd1) ? {off[1], 1'b1} : 2'b11;
        return {2'b00, up, off[2], 2'b00, be};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 cfg_mode", cfg_mode, 0);
        check("R12 drv_enable after reset", drv_enable, 1);
        check("R4 no smi after reset", smi_pulse, 0);
        check("R7 rd_valid idle", rd_valid, 0);

        // R7 normal read, R4 trap disabled
        acc(1'b0, 2'd0, 3'd0, 1'b0, 8'h00);
        check("R7 rd_valid", rd_valid, 1);
        check("R7 ones", rd_data, '1);
        check("R4 no smi with trap off", smi_pulse, 0);

        // R1 entry sequence with a byte read in between
        word_rd1();
        check("R1 first word read stays normal", cfg_mode, 0);
        acc(1'b0, 2'd0, 3'd1, 1'b0, 8'h00);
        acc(1'b0, 2'd2, 3'd1, 1'b0, 8'h00);
        check("R1 byte/dword read not counted", cfg_mode, 0);
        word_rd1();
        check("R1 second word read enters", cfg_mode, 1);
        check("R12 drv off in cfg", drv_enable, 0);

        cfg_rd(3'd3, 8'h01, "R11 ctrl reset");
        cfg_rd(3'd5, 8'h20, "R11 aux reset");
        cfg_rd(3'd2, 8'h00, "R10 ctl read smm low");
        cfg_rd(3'd4, 8'h00, "R11 trap data reset");
        cfg_rd(3'd7, 8'hFF, "R13 offset 7");
        check("R4 no smi in cfg", smi_pulse, 0);

        // R9 write masks
        cfg_wr(3'd3, 8'hFF); cfg_rd(3'd3, 8'hDF, "R9 ctrl bit5");
        cfg_wr(3'd5, 8'hFF); cfg_rd(3'd5, 8'hA7, "R9 aux all ones");
        cfg_wr(3'd5, 8'h00); cfg_rd(3'd5, 8'h20, "R9 aux zeros");

        // R8 banking
        cfg_wr(3'd6, 8'h00); cfg_wr(3'd0, 8'h11); cfg_wr(3'd1, 8'h22);
        cfg_wr(3'd6, 8'h01); cfg_wr(3'd0, 8'h33); cfg_wr(3'd1, 8'h44);
        cfg_rd(3'd0, 8'h33, "R8 bank1 lo"); cfg_rd(3'd1, 8'h44, "R8 bank1 hi");
        cfg_rd(3'd6, 8'h01, "R10 select readback");
        cfg_wr(3'd6, 8'h00);
        cfg_rd(3'd0, 8'h11, "R8 bank0 lo"); cfg_rd(3'd1, 8'h22, "R8 bank0 hi");

        // R13 ignored writes
        cfg_wr(3'd4, 8'h55); cfg_wr(3'd7, 8'h66);
        cfg_rd(3'd4, 8'h00, "R13 offset 4 write ignored");
        cfg_rd(3'd7, 8'hFF, "R13 offset 7 write ignored");

        // R2 non-exit write, then exit
        cfg_wr(3'd2, 8'h3D);
        check("R2 no exit without bits 7/6", cfg_mode, 1);
        cfg_wr(3'd3, 8'h03);
        cfg_rd(3'd3, 8'h03, "R10 ctrl readback");
        cfg_wr(3'd2, 8'h80);
        check("R2 exit on bit 7", cfg_mode, 0);
        check("R12 drv back on", drv_enable, 1);

        // R4 R5 R6 R7 sweep of trapped accesses
        for (int up = 0; up < 2; up++)
            for (int off = 0; off < 8; off++)
                for (int sz = 0; sz < 3; sz++)
                    for (int w = 0; w < 2; w++) begin
                        logic [7:0] d;
                        if (w == 0 && sz == 1 && off == 1) continue;
                        d = 8'(off * 16 + sz * 4 + up * 2 + w + 8'h40);
                        acc(w[0], sz[1:0], off[2:0], up[0], d);
                        check("R4 smi on trapped access", smi_pulse, 1);
                        check("R5 trap code", trap_code, exp_code(up[0], off[2:0], sz[1:0]));
                        check("R6 trap data", trap_data, (w == 1 && sz == 0) ? d : 8'h00);
                        if (w == 0) check("R7 trapped read ones", rd_data, '1);
                        @(negedge clk);
                        check("R4 smi single cycle", smi_pulse, 0);
                    end

        // R10 capture seen through offset 2 with SMM active
        acc(1'b0, 2'd1, 3'd1, 1'b1, 8'h00);
        acc(1'b0, 2'd1, 3'd1, 1'b1, 8'h00);
        check("R1 re-entry", cfg_mode, 1);
        smm_active = 1'b1;
        cfg_rd(3'd2, 8'hA1, "R10 ctl read smm high");
        smm_active = 1'b0;

        // R3 lock
        cfg_wr(3'd3, 8'h01);
        cfg_wr(3'd2, 8'h40);
        check("R2 exit on bit 6", cfg_mode, 0);
        acc(1'b1, 2'd0, 3'd3, 1'b0, 8'h12);
        check("R4 trap disabled", smi_pulse, 0);
        for (int k = 0; k < 4; k++) word_rd1();
        check("R3 locked no entry", cfg_mode, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule